// File: doc/BRIEF.md
# Dual-Tone Frequency Discriminator

This block sits behind two external limiting comparators in a touch-tone receiver. Each comparator gives a one-bit square wave: one carries the low (row) frequency group, the other the high (column) group. For each wave the block counts clock cycles between rising edges. It then decides whether that period falls inside the window of one of the four nominal tones of its group.

A group counts as valid only after several consecutive periods have landed in the same window. This averaging guards against speech that briefly resembles a tone. When both groups are valid at the same time, the block raises a registered early-detect flag and loads the row and column indices of the pair. Those indices hold until the next accepted pair.

An inhibit input masks the fourth column tone. A power-down input halts detection and clears all state. Guard-time validation of tone duration is done further downstream.

Top module: `dtmf_discrim`

## Requirements
- R1: Low-group tones of 697, 770, 852 and 941 Hz are reported on `row_idx` as codes 0, 1, 2 and 3 respectively.
- R2: High-group tones of 1209, 1336, 1477 and 1633 Hz are reported on `col_idx` as codes 0, 1, 2 and 3 respectively.
- R3: A tone whose frequency deviates from nominal by no more than 1.5% + 2 Hz, in either direction, is accepted.
- R4: A tone deviating from nominal by 3.5% or more, in either direction, is rejected, and `early_det` stays low.
- R5: `early_det` is high only while both groups hold a valid tone. It falls after either group loses validity.
- R6: While `inhibit` is high, a 1633 Hz column tone never yields `early_det`; the other three columns are unaffected.
- R7: While `pwrdn` is high, `early_det` is low one cycle later and no detection progresses. After release, a tone must be reacquired from scratch.
- R8: A group becomes valid only after one arming edge followed by CONFIRM_N consecutive periods in the same window. A tone lasting fewer periods never raises `early_det`.
- R9: `row_idx` and `col_idx` change only in the cycle `early_det` is registered high. Otherwise they hold the last accepted pair.
- R10: After reset, `early_det` is 0 and both indices are 0.
- R11: When no rising edge arrives for longer than the slowest window of a group, that group loses validity and `early_det` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_wave | input | 1 | Limited low-group square wave (asynchronous) |
| hi_wave | input | 1 | Limited high-group square wave (asynchronous) |
| inhibit | input | 1 | Masks the fourth column tone when high |
| pwrdn | input | 1 | Stops detection and clears state when high |
| early_det | output | 1 | Both groups currently hold a valid tone |
| row_idx | output | 2 | Row code of the last accepted pair |
| col_idx | output | 2 | Column code of the last accepted pair |

## Verification
The bench builds the block with CLK_HZ = 200000 and the default CONFIRM_N = 4. At that clock rate, tone periods fall between about 120 and 290 cycles. That is short enough to run every row and column, both sides of the tolerance bands, and the inhibit, power-down and timeout cases within the cycle budget. It is still fine enough that a 1.5% deviation and a 4% deviation land on different sides of each window edge. Keeping CONFIRM_N at its default lets the bench check the confirmation latency exactly: the flag must be absent after three low-group periods and present after six.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Nominal tone frequency: high=0 selects the row group, high=1 the column group.
  function automatic int tone_hz(input bit high, input int k);
    int f;
    if (!high) begin
      case (k)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (k)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Window edges sit at +/-2.5% in frequency: between the accept and reject bands.
  function automatic int win_min(input int clk_hz, input int f);
    return int'((longint'(clk_hz) * 1000) / (longint'(f) * 1025));
  endfunction

  function automatic int win_max(input int clk_hz, input int f);
    return int'((longint'(clk_hz) * 1000) / (longint'(f) * 975));
  endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wave_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], wave_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dtmf_period_class.sv
module dtmf_period_class #(
  parameter int CLK_HZ    = 3579545,
  parameter int CONFIRM_N = 4,
  parameter bit HIGH_GRP  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rise,
  output logic       valid,
  output logic [1:0] idx
);
  localparam int TMO = dtmf_pkg::win_max(CLK_HZ, dtmf_pkg::tone_hz(HIGH_GRP, 0));
  localparam int CW  = $clog2(TMO + 2);
  localparam int RW  = $clog2(CONFIRM_N + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] run_q, run_d;
  logic [1:0]    idx_q, idx_d;
  logic          armed_q, armed_d;
  logic [3:0]    hit;
  logic [1:0]    hit_idx;
  logic          hit_any;
  logic          timed_out;

  for (genvar k = 0; k < 4; k++) begin : g_win
    localparam int F  = dtmf_pkg::tone_hz(HIGH_GRP, k);
    localparam int LO = dtmf_pkg::win_min(CLK_HZ, F);
    localparam int HI = dtmf_pkg::win_max(CLK_HZ, F);
    assign hit[k] = (cnt_q >= CW'(LO)) && (cnt_q <= CW'(HI));
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int k = 0; k < 4; k++) begin
      if (hit[k]) hit_idx = 2'(k);
    end
  end

  assign hit_any   = |hit;
  assign timed_out = cnt_q > CW'(TMO);

  always_comb begin
    cnt_d   = cnt_q;
    run_d   = run_q;
    idx_d   = idx_q;
    armed_d = armed_q;
    if (clr) begin
      cnt_d   = '0;
      run_d   = '0;
      idx_d   = 2'd0;
      armed_d = 1'b0;
    end else if (rise) begin
      cnt_d   = CW'(1);
      armed_d = 1'b1;
      if (armed_q && hit_any) begin
        if (hit_idx == idx_q && run_q != '0) begin
          if (run_q != RW'(CONFIRM_N)) run_d = run_q + RW'(1);
        end else begin
          idx_d = hit_idx;
          run_d = RW'(1);
        end
      end else begin
        run_d = '0;
      end
    end else if (timed_out) begin
      armed_d = 1'b0;
      run_d   = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= '0;
      idx_q   <= 2'd0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      idx_q   <= idx_d;
      armed_q <= armed_d;
    end
  end

  assign valid = (run_q == RW'(CONFIRM_N));
  assign idx   = idx_q;
endmodule

// File: rtl/dtmf_discrim.sv
module dtmf_discrim #(
  parameter int CLK_HZ    = 3579545,
  parameter int CONFIRM_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_wave,
  input  logic       hi_wave,
  input  logic       inhibit,
  input  logic       pwrdn,
  output logic       early_det,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx
);
  logic [1:0]      wave;
  logic [1:0]      rise;
  logic [1:0]      grp_valid;
  logic [1:0][1:0] grp_idx;
  logic            col_blocked;
  logic            pair_ok;
  logic            flag_q;
  logic [1:0]      row_q, row_d, col_q, col_d;

  assign wave = {hi_wave, lo_wave};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    dtmf_edge_sync #(.STAGES(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .wave_i (wave[g]),
      .rise_o (rise[g])
    );
    dtmf_period_class #(
      .CLK_HZ    (CLK_HZ),
      .CONFIRM_N (CONFIRM_N),
      .HIGH_GRP  (g == 1)
    ) u_cls (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pwrdn),
      .rise  (rise[g]),
      .valid (grp_valid[g]),
      .idx   (grp_idx[g])
    );
  end

  assign col_blocked = inhibit && (grp_idx[1] == 2'd3);
  assign pair_ok     = grp_valid[0] && grp_valid[1] && !col_blocked && !pwrdn;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (pair_ok) begin
      row_d = grp_idx[0];
      col_d = grp_idx[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      row_q  <= 2'd0;
      col_q  <= 2'd0;
    end else begin
      flag_q <= pair_ok;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  assign early_det = flag_q;
  assign row_idx   = row_q;
  assign col_idx   = col_q;
endmodule

// File: rtl/dtmf_discrim_chk.sv
module dtmf_discrim_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrdn,
  input logic       inhibit,
  input logic       early_det,
  input logic [1:0] row_idx,
  input logic [1:0] col_idx,
  input logic [1:0] grp_valid
);
  a_r5_needs_both_groups: assert property (@(posedge clk) disable iff (!rst_n)
    early_det |-> $past(grp_valid[0] && grp_valid[1]));

  a_r7_pwrdn_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !early_det);

  a_r6_inhibit_masks_col3: assert property (@(posedge clk) disable iff (!rst_n)
    (early_det && $past(inhibit)) |-> (col_idx != 2'd3));

  a_r9_indices_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !early_det |-> ($stable(row_idx) && $stable(col_idx)));
endmodule

bind dtmf_discrim dtmf_discrim_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwrdn     (pwrdn),
  .inhibit   (inhibit),
  .early_det (early_det),
  .row_idx   (row_idx),
  .col_idx   (col_idx),
  .grp_valid (grp_valid)
);

// File: tb/dtmf_discrim_bench.sv
module dtmf_discrim_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 200000;
  localparam int CONFIRM_N  = 4;
  localparam int NVEC       = 10;
  // lo_hz, lo_dev_permille, hi_hz (0 = off), hi_dev_permille, inhibit, exp_flag, exp_row, exp_col
  localparam int VEC [NVEC][8] = '{
    '{697,   0, 1209,   0, 0, 1, 0, 0},
    '{770,   0, 1336,   0, 0, 1, 1, 1},
    '{852,  15, 1477, -15, 0, 1, 2, 2},
    '{941, -15, 1633,  15, 0, 1, 3, 3},
    '{941,   0, 1633,   0, 1, 0, 3, 3},
    '{852,   0, 1477,   0, 1, 1, 2, 2},
    '{697,  40, 1209,   0, 0, 0, 2, 2},
    '{770,   0, 1336, -40, 0, 0, 2, 2},
    '{697,   0,    0,   0, 0, 0, 2, 2},
    '{941, -40, 1209,   0, 0, 0, 2, 2}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lo_wave, hi_wave, inhibit, pwrdn;
  logic       early_det;
  logic [1:0] row_idx, col_idx;

  int lo_per = 0, hi_per = 0, lo_ph = 0, hi_ph = 0;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmf_discrim #(.CLK_HZ(CLK_HZ), .CONFIRM_N(CONFIRM_N)) u_dtmf_discrim (
    .clk(clk), .rst_n(rst_n), .lo_wave(lo_wave), .hi_wave(hi_wave),
    .inhibit(inhibit), .pwrdn(pwrdn), .early_det(early_det),
    .row_idx(row_idx), .col_idx(col_idx)
  );

  always @(negedge clk) begin
    if (lo_per == 0) begin lo_wave <= 1'b0; lo_ph <= 0; end
    else begin
      lo_wave <= (lo_ph < lo_per / 2);
      lo_ph   <= (lo_ph + 1 >= lo_per) ? 0 : lo_ph + 1;
    end
    if (hi_per == 0) begin hi_wave <= 1'b0; hi_ph <= 0; end
    else begin
      hi_wave <= (hi_ph < hi_per / 2);
      hi_ph   <= (hi_ph + 1 >= hi_per) ? 0 : hi_ph + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int per_of(input int f, input int dev_pm);
    if (f == 0) return 0;
    return $rtoi(real'(CLK_HZ) / (real'(f) * (1.0 + real'(dev_pm) / 1000.0)) + 0.5);
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int p697;
    rst_n = 1'b0; inhibit = 1'b0; pwrdn = 1'b0;
    wait_cyc(5);
    // R10: reset state
    chk("R10 flag", int'(early_det), 0);
    chk("R10 row", int'(row_idx), 0);
    chk("R10 col", int'(col_idx), 0);
    rst_n = 1'b1;
    wait_cyc(3);

    // Table walk: R1, R2, R3, R4, R5, R6, R9
    for (int v = 0; v < NVEC; v++) begin
      lo_per = 0; hi_per = 0;
      wait_cyc(400);
      inhibit = VEC[v][4][0];
      lo_per  = per_of(VEC[v][0], VEC[v][1]);
      hi_per  = per_of(VEC[v][2], VEC[v][3]);
      wait_cyc(7 * lo_per + 50);
      chk($sformatf("R1/R2/R3/R4/R5/R6 vec%0d flag", v), int'(early_det), VEC[v][5]);
      chk($sformatf("R1/R9 vec%0d row", v), int'(row_idx), VEC[v][6]);
      chk($sformatf("R2/R9 vec%0d col", v), int'(col_idx), VEC[v][7]);
    end
    inhibit = 1'b0;

    // R8: confirmation latency
    lo_per = 0; hi_per = 0;
    wait_cyc(400);
    p697   = per_of(697, 0);
    lo_per = p697; hi_per = per_of(1209, 0);
    wait_cyc(3 * p697);
    chk("R8 not yet confirmed", int'(early_det), 0);
    wait_cyc(3 * p697);
    chk("R8 confirmed", int'(early_det), 1);
    chk("R1 row 697", int'(row_idx), 0);

    // R11 / R5: high group goes silent
    hi_per = 0;
    wait_cyc(250);
    chk("R11 timeout drops flag", int'(early_det), 0);
    chk("R9 hold row after drop", int'(row_idx), 0);
    chk("R9 hold col after drop", int'(col_idx), 0);

    // R7: power-down
    hi_per = per_of(1336, 0);
    wait_cyc(6 * p697);
    chk("R7 pre pwrdn flag", int'(early_det), 1);
    pwrdn = 1'b1;
    wait_cyc(1);
    chk("R7 flag low after pwrdn", int'(early_det), 0);
    wait_cyc(2000);
    chk("R7 flag stays low", int'(early_det), 0);
    chk("R7 col unchanged", int'(col_idx), 1);
    pwrdn = 1'b0;
    wait_cyc(2);
    chk("R7 no instant resume", int'(early_det), 0);
    wait_cyc(6 * p697);
    chk("R7 reacquired", int'(early_det), 1);
    chk("R2 col 1336", int'(col_idx), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule